// File: doc/BRIEF.md
# Two-Stage 192-bit Hash Compression Core

The core compresses one 512-bit message block into a 192-bit chaining value. Six 32-bit working words are advanced by 64 steps, one per clock. Each step runs two stages back to back. The first stage is SHA-1-like: a round function, a round constant and a rotated copy of the first word feed an adder chain. The second stage is MD5-like: a second Boolean function, a per-step additive constant and a per-step left rotation update the second word, and the six words rotate by one position.

When the last step finishes, the working words are added word by word into the chaining value, and a done flag rises. The digest holds until the next accepted start. A caller hashing a long message sets `first_i` on the first block, so that the chain restarts from the initial value. On the following blocks it clears `first_i`, so that each block continues from the previous digest. Padding and splitting the message into blocks are done outside the core.

Top module: `hc192_core`

## Requirements
- R1: After reset, `done_o` is 0 and `digest_o` equals the initial value 67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0_40385172 (word A in bits 191:160 down to word F in bits 31:0).
- R2: Schedule word W0 is `block_i[511:480]`, W1 is `block_i[479:448]` and so on down to W15 = `block_i[31:0]`. The block is captured on the accepting edge, so later changes to `block_i` have no effect on the result.
- R3: A start accepted with `first_i`=1 begins from the initial value of R1. With `first_i`=0 it begins from the current digest.
- R4: For steps t of 16 and above, Wt = W(t-3) ^ W(t-8) ^ W(t-14) ^ W(t-16), with no rotation.
- R5: Stage one computes T = rotl(a,2) + f(b,c,d) + e + K + Wt. Its results are a=T+f_reg, b=rotl(a,5), c=rotl(b,15), d=c, e=d and f=T. By round of 16 steps, f and K are: choose (b&c)|(~b&d) with 5A827999; parity b^c^d with 6ED9EBA1; majority with 8F1BBCDC; parity with CA62C1D6.
- R6: Stage two works on the stage-one results. It sets b = b + rotl(a + p(b,c,d) + Wt + tk[t], s), a = old f, f = e, e = d, d = c and c = old b. Here tk[t] = floor(|sin(t+1)|·2^32). By round, p is (b&c)|(~b&d), (d&b)|(~d&c), b&c&d and c&(b|~d). The rotation s cycles by round through {7,12,17,22}, {5,9,14,20}, {4,11,16,23} and {6,10,15,21}.
- R7: After step 63, each chaining word becomes its old value plus the matching working word, modulo 2^32.
- R8: `done_o` rises exactly 64 clock edges after the edge that accepts a start, and the new digest appears on that same edge.
- R9: An accepted start clears `done_o` on the next edge. While no start is accepted, `done_o` and `digest_o` hold their values.
- R10: A start that arrives while a block is in progress is ignored. It changes neither the result nor its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin compressing `block_i` (accepted only when idle) |
| first_i | input | 1 | Restart the chain from the initial value |
| block_i | input | 512 | Padded message block, W0 in the top bits |
| digest_o | output | 192 | Chaining value, word A in the top bits |
| done_o | output | 1 | Digest valid, held until the next accepted start |

## Verification
Any error in one schedule word, round selection, constant or rotation spreads through the following steps. It therefore shows up as a wholly different `digest_o` at the rise of `done_o`, 64 cycles after the start. The bench compares every digest against an independent model. A control fault shows in other ways. A miscounted step counter moves the done edge off cycle 64. A broken idle guard lets a stray start alter the digest or the timing. A chaining fault shows only on the second block of a chain, so chained and restarted sequences are both run.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int WORD_W   = 32;
  localparam int N_WORDS  = 6;
  localparam int BLK_WORDS = 16;
  localparam int BLK_W    = WORD_W * BLK_WORDS;
  localparam int DIG_W    = WORD_W * N_WORDS;
  localparam int N_STEPS  = 64;
  localparam int STEP_W   = $clog2(N_STEPS);

  typedef logic [WORD_W-1:0] word_t;
  // element 0 is word A and sits in the most significant bits
  typedef logic [0:N_WORDS-1][WORD_W-1:0] hstate_t;

  localparam hstate_t INIT_VAL = {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                                  32'h10325476, 32'hC3D2E1F0, 32'h40385172};

  localparam word_t ADD_TAB [N_STEPS] = '{
    32'hd76aa478, 32'he8c7b756, 32'h242070db, 32'hc1bdceee,
    32'hf57c0faf, 32'h4787c62a, 32'ha8304613, 32'hfd469501,
    32'h698098d8, 32'h8b44f7af, 32'hffff5bb1, 32'h895cd7be,
    32'h6b901122, 32'hfd987193, 32'ha679438e, 32'h49b40821,
    32'hf61e2562, 32'hc040b340, 32'h265e5a51, 32'he9b6c7aa,
    32'hd62f105d, 32'h02441453, 32'hd8a1e681, 32'he7d3fbc8,
    32'h21e1cde6, 32'hc33707d6, 32'hf4d50d87, 32'h455a14ed,
    32'ha9e3e905, 32'hfcefa3f8, 32'h676f02d9, 32'h8d2a4c8a,
    32'hfffa3942, 32'h8771f681, 32'h6d9d6122, 32'hfde5380c,
    32'ha4beea44, 32'h4bdecfa9, 32'hf6bb4b60, 32'hbebfbc70,
    32'h289b7ec6, 32'heaa127fa, 32'hd4ef3085, 32'h04881d05,
    32'hd9d4d039, 32'he6db99e5, 32'h1fa27cf8, 32'hc4ac5665,
    32'hf4292244, 32'h432aff97, 32'hab9423a7, 32'hfc93a039,
    32'h655b59c3, 32'h8f0ccc92, 32'hffeff47d, 32'h85845dd1,
    32'h6fa87e4f, 32'hfe2ce6e0, 32'ha3014314, 32'h4e0811a1,
    32'hf7537e82, 32'hbd3af235, 32'h2ad7d2bb, 32'heb86d391
  };

  localparam word_t RND_K [4] = '{32'h5A827999, 32'h6ED9EBA1,
                                  32'h8F1BBCDC, 32'hCA62C1D6};

  function automatic word_t rotl(input word_t x, input logic [4:0] n);
    logic [2*WORD_W-1:0] tmp;
    tmp = {x, x} << n;
    return tmp[2*WORD_W-1:WORD_W];
  endfunction

  function automatic logic [4:0] rot_amt(input logic [1:0] rnd, input logic [1:0] pos);
    logic [4:0] r;
    unique case ({rnd, pos})
      4'h0: r = 5'd7;  4'h1: r = 5'd12; 4'h2: r = 5'd17; 4'h3: r = 5'd22;
      4'h4: r = 5'd5;  4'h5: r = 5'd9;  4'h6: r = 5'd14; 4'h7: r = 5'd20;
      4'h8: r = 5'd4;  4'h9: r = 5'd11; 4'hA: r = 5'd16; 4'hB: r = 5'd23;
      4'hC: r = 5'd6;  4'hD: r = 5'd10; 4'hE: r = 5'd15; default: r = 5'd21;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/hc_sched.sv
module hc_sched
  import hc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  input  logic [BLK_W-1:0] blk,
  output word_t            w_cur
);
  word_t win [BLK_WORDS];
  word_t nxt_word;

  // window holds W(t)..W(t+15); next entry is W(t+16)
  assign nxt_word = win[13] ^ win[8] ^ win[2] ^ win[0];
  assign w_cur    = win[0];

  for (genvar i = 0; i < BLK_WORDS; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        win[i] <= '0;
      end else if (load) begin
        win[i] <= blk[BLK_W-1-WORD_W*i -: WORD_W];
      end else if (adv) begin
        if (i == BLK_WORDS-1) win[i] <= nxt_word;
        else                  win[i] <= win[i+1];
      end
    end
  end
endmodule

// File: rtl/hc_step.sv
module hc_step
  import hc_pkg::*;
(
  input  hstate_t           cur,
  input  word_t             w,
  input  logic [STEP_W-1:0] t,
  output hstate_t           nxt
);
  logic [1:0] rnd;
  word_t a, b, c, d, e, f;
  word_t fv, tsum, a1, b1, c1, d1, e1, f1, pv, mix;

  assign rnd = t[STEP_W-1 -: 2];
  assign {a, b, c, d, e, f} = cur;

  // stage one
  always_comb begin
    unique case (rnd)
      2'd0:    fv = (b & c) | (~b & d);
      2'd2:    fv = (b & c) | (b & d) | (c & d);
      default: fv = b ^ c ^ d;
    endcase
    tsum = rotl(a, 5'd2) + fv + e + RND_K[rnd] + w;
    a1 = tsum + f;
    b1 = rotl(a, 5'd5);
    c1 = rotl(b, 5'd15);
    d1 = c;
    e1 = d;
    f1 = tsum;
  end

  // stage two on the stage-one results
  always_comb begin
    unique case (rnd)
      2'd0:    pv = (b1 & c1) | (~b1 & d1);
      2'd1:    pv = (d1 & b1) | (~d1 & c1);
      2'd2:    pv = b1 & c1 & d1;
      default: pv = c1 & (b1 | ~d1);
    endcase
    mix = rotl(a1 + pv + w + ADD_TAB[t], rot_amt(rnd, t[1:0]));
    nxt = {f1, b1 + mix, b1, c1, d1, e1};
  end
endmodule

// File: rtl/hc192_core.sv
module hc192_core
  import hc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             first_i,
  input  logic [511:0]     block_i,
  output logic [191:0]     digest_o,
  output logic             done_o
);
  logic              busy_q, done_q, accept;
  logic [STEP_W-1:0] step_q;
  hstate_t           work_q, chain_q, step_nx, chain_sum;
  word_t             w_cur;

  assign accept = start_i && !busy_q;

  hc_sched u_sched (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .adv  (busy_q),
    .blk  (block_i),
    .w_cur(w_cur)
  );

  hc_step u_step (
    .cur(work_q),
    .w  (w_cur),
    .t  (step_q),
    .nxt(step_nx)
  );

  for (genvar i = 0; i < N_WORDS; i++) begin : g_add
    assign chain_sum[i] = chain_q[i] + step_nx[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= '0;
      work_q  <= '0;
      chain_q <= INIT_VAL;
    end else if (accept) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      step_q <= '0;
      if (first_i) begin
        chain_q <= INIT_VAL;
        work_q  <= INIT_VAL;
      end else begin
        work_q  <= chain_q;
      end
    end else if (busy_q) begin
      work_q <= step_nx;
      step_q <= step_q + 1'b1;
      if (step_q == STEP_W'(N_STEPS-1)) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        chain_q <= chain_sum;
      end
    end
  end

  assign digest_o = chain_q;
  assign done_o   = done_q;
endmodule

// File: rtl/hc192_core_chk.sv
module hc192_core_chk (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         busy,
  input logic         done_o,
  input logic [191:0] digest_o
);
  logic [7:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)                    run_len <= '0;
    else if (start_i && !busy)  run_len <= '0;
    else if (busy)              run_len <= run_len + 1'b1;
  end

  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> run_len == 8'd64);

  a_r8_done_after_run: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(busy));

  a_r9_clear_on_start: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy) |=> !done_o);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_i) |=> ($stable(digest_o) && $stable(done_o)));

  a_r10_run_continues: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || $rose(done_o)));
endmodule

bind hc192_core hc192_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .busy    (busy_q),
  .done_o  (done_o),
  .digest_o(digest_o)
);

// File: tb/hc192_core_tb_top.sv
`timescale 1ns/1ps
module hc192_core_tb_top;
  localparam logic [191:0] IV = {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                                 32'h10325476, 32'hC3D2E1F0, 32'h40385172};

  logic         clk = 1'b0;
  logic         rst, start, first;
  logic [511:0] blk;
  logic [191:0] digest;
  logic         done;

  int checks = 0, errors = 0;
  longint unsigned cyc = 0;
  logic [191:0] exp_q[$];
  longint unsigned t0_q[$];
  logic [191:0] mchain;
  bit pdone = 1'b0;
  int rot_tab [4][4] = '{'{7,12,17,22}, '{5,9,14,20}, '{4,11,16,23}, '{6,10,15,21}};

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hc192_core dut_i (
    .clk(clk), .rst(rst), .start_i(start), .first_i(first),
    .block_i(blk), .digest_o(digest), .done_o(done)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] tkc(input int i);
    real v;
    v = $sin(real'(i + 1));
    if (v < 0.0) v = -v;
    v = $floor(v * 4294967296.0);
    return 32'(longint'(v));
  endfunction

  function automatic logic [191:0] model(input logic [191:0] h, input logic [511:0] m);
    logic [31:0] w [64];
    logic [31:0] a, b, c, d, e, f, fv, pv, k, tt, nb;
    for (int t = 0; t < 16; t++) w[t] = m[511-32*t -: 32];
    for (int t = 16; t < 64; t++) w[t] = w[t-3] ^ w[t-8] ^ w[t-14] ^ w[t-16];
    {a, b, c, d, e, f} = h;
    for (int t = 0; t < 64; t++) begin
      case (t / 16)
        0: begin fv = (b & c) | (~b & d); k = 32'h5A827999; end
        1: begin fv = b ^ c ^ d; k = 32'h6ED9EBA1; end
        2: begin fv = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
        default: begin fv = b ^ c ^ d; k = 32'hCA62C1D6; end
      endcase
      tt = rl(a, 2) + fv + e + k + w[t];
      {a, b, c, d, e, f} = {tt + f, rl(a, 5), rl(b, 15), c, d, tt};
      case (t / 16)
        0: pv = (b & c) | (~b & d);
        1: pv = (d & b) | (~d & c);
        2: pv = b & c & d;
        default: pv = c & (b | ~d);
      endcase
      nb = b + rl(a + pv + w[t] + tkc(t), rot_tab[t/16][t%4]);
      {a, b, c, d, e, f} = {f, nb, b, c, d, e};
    end
    return {h[191:160] + a, h[159:128] + b, h[127:96] + c,
            h[95:64] + d, h[63:32] + e, h[31:0] + f};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] rnd_blk();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  // monitor: pop expected digest and start time at each done rise
  always @(negedge clk) begin
    if (!rst) begin
      if (done && !pdone) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected done", digest, '0);
        end else begin
          logic [191:0] e;
          longint unsigned t0;
          e  = exp_q.pop_front();
          t0 = t0_q.pop_front();
          chk(digest === e, "R2/R4/R5/R6/R7 digest", digest, e);
          chk(cyc - t0 == 64, "R8 latency", 192'(cyc - t0), 192'd64);
        end
      end
      pdone = done;
    end
  end

  task automatic run_block(input logic [511:0] m, input bit fst, input int stray_at);
    logic [191:0] e;
    e = model(fst ? IV : mchain, m);
    mchain = e;
    @(negedge clk);
    blk = m; first = fst; start = 1'b1;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    t0_q.push_back(cyc);
    blk = ~m;  // R2: block captured on accept
    chk(done == 1'b0, "R9 done cleared by start", 192'(done), 192'd0);
    if (stray_at > 0) begin
      repeat (stray_at - 1) @(negedge clk);
      blk = rnd_blk(); first = 1'b1; start = 1'b1;  // R10 stray start
      @(negedge clk);
      start = 1'b0; first = fst;
    end
    while (exp_q.size() != 0) @(negedge clk);
    chk(digest === e, "R3/R7 digest after run", digest, e);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [191:0] held;
    rst = 1'b1; start = 1'b0; first = 1'b0; blk = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(digest === IV, "R1 reset digest", digest, IV);
    chk(done === 1'b0, "R1 reset done", 192'(done), 192'd0);

    run_block('0, 1'b1, 0);                                   // all-zero block
    run_block({32'h61626380, 416'd0, 64'd24}, 1'b1, 0);       // short padded message
    run_block({32'h80000000, 448'd0, 32'd0}, 1'b0, 0);        // R3 chained block
    run_block({32'hFFFFFFFF, 480'd0}, 1'b1, 0);               // R2 only W0 set
    run_block({480'd0, 32'h00000001}, 1'b0, 0);               // R2 only W15 set, chained
    run_block(rnd_blk(), 1'b1, 20);                           // R10 stray start mid-run
    run_block(rnd_blk(), 1'b0, 62);                           // R10 stray start near end

    // R9: hold while idle with inputs changing
    held = digest;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      blk = rnd_blk(); first = i[0];
    end
    chk(digest === held, "R9 digest held while idle", digest, held);
    chk(done === 1'b1, "R9 done held while idle", 192'(done), 192'd1);

    for (int i = 0; i < 3; i++) run_block(rnd_blk(), 1'b0, 0);  // R3 chain of three
    run_block(rnd_blk(), 1'b1, 0);                               // R3 restart
    repeat (4) @(negedge clk);
    finish_sim();
  end
endmodule